// File: doc/BRIEF.md
# Indirect configuration access bridge

This block lets a host reach the configuration registers of downstream devices through two small windows on a host register bus. The first window holds a 32-bit pointer register. That register carries an enable flag, a bus number, a device/function number and a register offset. The second window is a four-byte data port. A data-port access is turned into one configuration transaction, addressed by the pointer register. The low two bits of the data-port byte offset are merged into the register offset, so byte and halfword accesses can reach registers that are not dword aligned.

The downstream side reports in the same cycle whether a device answers at the decoded bus and device/function. It also returns read data in that cycle. The host read response comes one clock later. Pointer-register writes are accepted only as aligned full dwords, so partial writes cannot corrupt the pointer. Reads from absent devices or through a disabled port return all ones. The forwarded length is trimmed so that it never runs past the end of configuration space. Host byte ordering, little or big endian, is chosen when the block is built.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the pointer register reads as 0, the data port is disabled, and `cfg_valid_o` and `rvalid_o` are low.
- R2: A write to the pointer window (`win_i`=0) loads the register only when `off_i`=0 and `len_i`=4. Any other pointer-window write leaves the register unchanged.
- R3: A read of the pointer window returns the whole 32-bit register for any `off_i` and `len_i`.
- R4: Pointer bit 31 enables the data port (`win_i`=1). When bit 31 is clear, data writes raise no `cfg_valid_o` and data reads return 32'hFFFF_FFFF.
- R5: For a data access, `cfg_bus_o` is pointer bits 23:16 and `cfg_devfn_o` is pointer bits 15:8. `cfg_reg_o` is (pointer bits 7:0 OR `off_i`[1:0]), taken modulo the configuration space size.
- R6: `cfg_len_o` equals the smaller of `len_i` and (CFG_BYTES minus `cfg_reg_o`).
- R7: When `cfg_present_i` is low, a data write raises no `cfg_valid_o` and a data read returns 32'hFFFF_FFFF.
- R8: Every host read raises `rvalid_o` for one cycle, in the cycle after the request. A device read returns `cfg_rdata_i` cut to `cfg_len_o` bytes and placed in the low bytes, with the upper bytes zero.
- R9: With BIG_ENDIAN=1, host data is byte-reversed within `len_i` bytes on both write and read. The pointer register is byte-reversed as a 4-byte value. All-ones responses are returned unchanged.
- R10: `cfg_valid_o` is a single-cycle pulse in the request cycle, with `cfg_we_o` following `we_i`. `cfg_wdata_o` carries the host data cut to `len_i` bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| win_i | input | 1 | 0 = pointer window, 1 = data window |
| off_i | input | 2 | Byte offset inside the window |
| len_i | input | 3 | Access length in bytes: 1, 2 or 4 |
| wdata_i | input | 32 | Host write data |
| rvalid_o | output | 1 | Read response valid |
| rdata_o | output | 32 | Read response data |
| cfg_valid_o | output | 1 | Configuration transaction strobe |
| cfg_we_o | output | 1 | Transaction is a write |
| cfg_bus_o | output | 8 | Target bus number |
| cfg_devfn_o | output | 8 | Target device/function |
| cfg_reg_o | output | $clog2(CFG_BYTES) | Register offset |
| cfg_len_o | output | 3 | Trimmed length in bytes |
| cfg_wdata_o | output | 32 | Transaction write data |
| cfg_present_i | input | 1 | Device present at the decoded bus and device/function |
| cfg_rdata_i | input | 32 | Device read data |

## Verification
The bench builds two copies side by side with the default 256-byte configuration space, one with BIG_ENDIAN=0 and one with BIG_ENDIAN=1, and drives both with the same host traffic. The small space lets the sweep visit every pointer offset under all four window offsets and all three lengths. That reaches every trimmed length, including the 3-, 2- and 1-byte tails near offset 255. Deriving the bus number from the offset also places one absent device inside the sweep.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic {
    WIN_PTR  = 1'b0,
    WIN_DATA = 1'b1
  } win_e;

  // byte lanes covered by a length of 1..4
  function automatic logic [DW-1:0] lane_mask(input logic [2:0] len);
    case (len)
      3'd1:    lane_mask = 32'h0000_00ff;
      3'd2:    lane_mask = 32'h0000_ffff;
      3'd3:    lane_mask = 32'h00ff_ffff;
      default: lane_mask = 32'hffff_ffff;
    endcase
  endfunction

  // reverse bytes inside the low len bytes, zero above
  function automatic logic [DW-1:0] rev_bytes(input logic [DW-1:0] d,
                                              input logic [2:0]    len);
    case (len)
      3'd1:    rev_bytes = {24'd0, d[7:0]};
      3'd2:    rev_bytes = {16'd0, d[7:0], d[15:8]};
      3'd3:    rev_bytes = {8'd0, d[7:0], d[15:8], d[23:16]};
      default: rev_bytes = {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
  endfunction
endpackage

// File: rtl/cfgb_ptr_reg.sv
module cfgb_ptr_reg
  import cfgb_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [1:0]    off_i,
  input  logic [2:0]    len_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ptr_o
);
  logic take;

  // only aligned full-dword stores reach the pointer
  assign take = wr_i && (off_i == 2'd0) && (len_i == 3'd4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_o <= '0;
    else if (take) ptr_o <= wdata_i;
  end
endmodule

// File: rtl/cfgb_xlate.sv
module cfgb_xlate #(
  parameter int unsigned CFG_BYTES = 256,
  localparam int unsigned REG_W    = $clog2(CFG_BYTES)
) (
  input  logic [23:0]      ptr_i,
  input  logic [1:0]       off_i,
  input  logic [2:0]       len_i,
  output logic [7:0]       bus_o,
  output logic [7:0]       devfn_o,
  output logic [REG_W-1:0] reg_o,
  output logic [2:0]       len_o
);
  logic [REG_W:0] room;
  logic [REG_W:0] len_ext;

  assign bus_o   = ptr_i[23:16];
  assign devfn_o = ptr_i[15:8];
  assign reg_o   = ptr_i[REG_W-1:0] | REG_W'(off_i);

  // bytes left before the end of configuration space
  assign room    = (REG_W+1)'(CFG_BYTES) - {1'b0, reg_o};
  assign len_ext = (REG_W+1)'(len_i);
  assign len_o   = (len_ext > room) ? room[2:0] : len_i;
endmodule

// File: rtl/cfgb_resp.sv
module cfgb_resp
  import cfgb_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= rd_data_i;
    end
  end
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfgb_pkg::*;
#(
  parameter int unsigned CFG_BYTES  = 256,
  parameter bit          BIG_ENDIAN = 1'b0,
  localparam int unsigned REG_W     = $clog2(CFG_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             win_i,
  input  logic [1:0]       off_i,
  input  logic [2:0]       len_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             rvalid_o,
  output logic [DW-1:0]    rdata_o,
  output logic             cfg_valid_o,
  output logic             cfg_we_o,
  output logic [7:0]       cfg_bus_o,
  output logic [7:0]       cfg_devfn_o,
  output logic [REG_W-1:0] cfg_reg_o,
  output logic [2:0]       cfg_len_o,
  output logic [DW-1:0]    cfg_wdata_o,
  input  logic             cfg_present_i,
  input  logic [DW-1:0]    cfg_rdata_i
);
  logic [DW-1:0] addr_q;
  logic [DW-1:0] wd_ord, ptr_ord, dev_ord, dev_cut, rd_d;
  logic          ptr_acc, data_acc, port_en, answer;

  assign ptr_acc  = req_i && (win_i == WIN_PTR);
  assign data_acc = req_i && (win_i == WIN_DATA);
  assign port_en  = addr_q[DW-1];
  assign answer   = port_en && cfg_present_i;

  assign dev_cut  = cfg_rdata_i & lane_mask(cfg_len_o);

  generate
    if (BIG_ENDIAN) begin : g_be
      assign wd_ord  = rev_bytes(wdata_i, len_i);
      assign ptr_ord = rev_bytes(addr_q, 3'd4);
      assign dev_ord = rev_bytes(dev_cut, len_i);
    end else begin : g_le
      assign wd_ord  = wdata_i & lane_mask(len_i);
      assign ptr_ord = addr_q;
      assign dev_ord = dev_cut;
    end
  endgenerate

  cfgb_ptr_reg u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ptr_acc && we_i),
    .off_i   (off_i),
    .len_i   (len_i),
    .wdata_i (wd_ord),
    .ptr_o   (addr_q)
  );

  cfgb_xlate #(.CFG_BYTES(CFG_BYTES)) u_xlate (
    .ptr_i   (addr_q[23:0]),
    .off_i   (off_i),
    .len_i   (len_i),
    .bus_o   (cfg_bus_o),
    .devfn_o (cfg_devfn_o),
    .reg_o   (cfg_reg_o),
    .len_o   (cfg_len_o)
  );

  assign cfg_valid_o = data_acc && answer;
  assign cfg_we_o    = we_i;
  assign cfg_wdata_o = wd_ord;

  always_comb begin
    if (win_i == WIN_PTR) rd_d = ptr_ord;
    else if (!answer)     rd_d = '1;
    else                  rd_d = dev_ord;
  end

  cfgb_resp u_resp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (req_i && !we_i),
    .rd_data_i (rd_d),
    .rvalid_o  (rvalid_o),
    .rdata_o   (rdata_o)
  );
endmodule

// File: rtl/cfg_port_bridge_chk.sv
module cfg_port_bridge_chk #(
  parameter int unsigned CFG_BYTES = 256,
  localparam int unsigned REG_W    = $clog2(CFG_BYTES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic             win_i,
  input logic [1:0]       off_i,
  input logic [2:0]       len_i,
  input logic [31:0]      addr_q_i,
  input logic             cfg_valid_i,
  input logic [7:0]       cfg_bus_i,
  input logic [REG_W-1:0] cfg_reg_i,
  input logic [2:0]       cfg_len_i,
  input logic             rvalid_i,
  input logic [31:0]      rdata_i
);
  // R2
  bad_ptr_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !win_i && !(off_i == 2'd0 && len_i == 3'd4)) |=> $stable(addr_q_i));

  // R4
  valid_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i |-> addr_q_i[31]);

  // R4
  dis_rd_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && win_i && !addr_q_i[31]) |=> (rdata_i == 32'hffff_ffff));

  // R5
  bus_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i |-> (cfg_bus_i == addr_q_i[23:16]));

  // R6
  len_fits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i |-> (cfg_len_i != 3'd0 && cfg_len_i <= len_i &&
      ((REG_W+1)'(cfg_reg_i) + (REG_W+1)'(cfg_len_i)) <= (REG_W+1)'(CFG_BYTES)));

  // R8
  rvalid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_i);

  // R8
  rvalid_only_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_i);
endmodule

bind cfg_port_bridge cfg_port_bridge_chk #(.CFG_BYTES(CFG_BYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .win_i       (win_i),
  .off_i       (off_i),
  .len_i       (len_i),
  .addr_q_i    (addr_q),
  .cfg_valid_i (cfg_valid_o),
  .cfg_bus_i   (cfg_bus_o),
  .cfg_reg_i   (cfg_reg_o),
  .cfg_len_i   (cfg_len_o),
  .rvalid_i    (rvalid_o),
  .rdata_i     (rdata_o)
);

// File: tb/cfg_port_bridge_test.sv
module cfg_port_bridge_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0, win = 0;
  logic [1:0] off = 0;
  logic [2:0] len = 3'd4;
  logic [31:0] wd = 0, wd_be;

  logic rv_l, rv_b, cv_l, cv_b, cw_l, cw_b;
  logic [31:0] rd_l, rd_b, cwd_l, cwd_b, dev_l, dev_b;
  logic [7:0] bus_l, bus_b, dfn_l, dfn_b, reg_l, reg_b;
  logic [2:0] cl_l, cl_b;
  logic pr_l, pr_b;

  int checks = 0, fails = 0;
  logic [31:0] model_ptr = 0;

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rev(input logic [31:0] d, input int n);
    logic [31:0] o = '0;
    for (int i = 0; i < n; i++) o[8*i +: 8] = d[8*(n-1-i) +: 8];
    return o;
  endfunction

  function automatic logic [31:0] keep(input logic [31:0] d, input int n);
    logic [31:0] o = '0;
    for (int i = 0; i < n; i++) o[8*i +: 8] = d[8*i +: 8];
    return o;
  endfunction

  function automatic logic [31:0] dev_val(input logic [7:0] r, input logic [7:0] f);
    return {r + 8'd3, r + 8'd2, r + 8'd1, r} ^ {4{f}};
  endfunction

  // host presents pointer data in its own byte order to the big-endian copy
  assign wd_be = (win == 1'b0) ? rev(wd, 4) : wd;

  // device models: bus 8'hEE is absent
  assign pr_l  = (bus_l != 8'hee);
  assign pr_b  = (bus_b != 8'hee);
  assign dev_l = dev_val(reg_l, dfn_l);
  assign dev_b = dev_val(reg_b, dfn_b);

  cfg_port_bridge #(.BIG_ENDIAN(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .win_i(win),
    .off_i(off), .len_i(len), .wdata_i(wd), .rvalid_o(rv_l), .rdata_o(rd_l),
    .cfg_valid_o(cv_l), .cfg_we_o(cw_l), .cfg_bus_o(bus_l), .cfg_devfn_o(dfn_l),
    .cfg_reg_o(reg_l), .cfg_len_o(cl_l), .cfg_wdata_o(cwd_l),
    .cfg_present_i(pr_l), .cfg_rdata_i(dev_l));

  cfg_port_bridge #(.BIG_ENDIAN(1'b1)) uut_be (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .win_i(win),
    .off_i(off), .len_i(len), .wdata_i(wd_be), .rvalid_o(rv_b), .rdata_o(rd_b),
    .cfg_valid_o(cv_b), .cfg_we_o(cw_b), .cfg_bus_o(bus_b), .cfg_devfn_o(dfn_b),
    .cfg_reg_o(reg_b), .cfg_len_o(cl_b), .cfg_wdata_o(cwd_b),
    .cfg_present_i(pr_b), .cfg_rdata_i(dev_b));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // one host access on both copies, all outputs checked against the model
  task automatic acc(input bit w_win, input bit w_we, input logic [1:0] w_off,
                     input int w_len, input logic [31:0] w_d);
    logic [7:0] eff, mbus, mdfn;
    int room, clip;
    bit en, pres, go;
    logic [31:0] exp_l, exp_b, cut;
    @(negedge clk);
    req = 1; win = w_win; we = w_we; off = w_off; len = 3'(w_len); wd = w_d;
    mbus = model_ptr[23:16];
    mdfn = model_ptr[15:8];
    eff  = model_ptr[7:0] | {6'd0, w_off};
    room = 256 - int'(eff);
    clip = (w_len < room) ? w_len : room;
    en   = model_ptr[31];
    pres = (mbus != 8'hee);
    go   = w_win && en && pres;
    #1;
    // R4 R7 R10: strobe only for an enabled data access to a present device
    chk(cv_l == go, "R4 R7 R10 valid le", {31'd0, cv_l}, {31'd0, go});
    chk(cv_b == go, "R9 valid be", {31'd0, cv_b}, {31'd0, go});
    if (go) begin
      // R5 R6: fields and trimmed length
      chk({bus_l, dfn_l, reg_l, 5'd0, cl_l} == {mbus, mdfn, eff, 5'd0, 3'(clip)},
          "R5 R6 fields", {bus_l, dfn_l, reg_l, 5'd0, cl_l},
          {mbus, mdfn, eff, 5'd0, 3'(clip)});
      chk({bus_b, dfn_b, reg_b, 5'd0, cl_b} == {mbus, mdfn, eff, 5'd0, 3'(clip)},
          "R9 fields be", {bus_b, dfn_b, reg_b, 5'd0, cl_b},
          {mbus, mdfn, eff, 5'd0, 3'(clip)});
      if (w_we) begin
        chk(cw_l && cwd_l == keep(w_d, w_len), "R10 wdata le", cwd_l, keep(w_d, w_len));
        chk(cw_b && cwd_b == rev(w_d, w_len), "R9 wdata be", cwd_b, rev(w_d, w_len));
      end
    end
    if (!w_win && w_we && w_off == 2'd0 && w_len == 4) model_ptr = w_d;
    @(negedge clk);
    req = 0;
    #1;
    // R10: the strobe has dropped
    chk(!cv_l && !cv_b, "R10 pulse", {30'd0, cv_b, cv_l}, 32'd0);
    // R8: response one cycle after a read only
    chk(rv_l == !w_we && rv_b == !w_we, "R8 rvalid", {30'd0, rv_b, rv_l},
        {30'd0, !w_we, !w_we});
    if (!w_we) begin
      if (!w_win) begin
        exp_l = model_ptr;
        exp_b = rev(model_ptr, 4);
      end else if (!(en && pres)) begin
        exp_l = 32'hffff_ffff;
        exp_b = 32'hffff_ffff;
      end else begin
        cut   = keep(dev_val(eff, mdfn), clip);
        exp_l = cut;
        exp_b = rev(cut, w_len);
      end
      chk(rd_l == exp_l, "R3 R4 R7 R8 rdata le", rd_l, exp_l);
      chk(rd_b == exp_b, "R9 rdata be", rd_b, exp_b);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog act=%08h exp=%08h", 32'd1, 32'd0);
    summary();
    $finish;
  end

  initial begin
    int lens[3] = '{1, 2, 4};
    #(PERIOD * 3);
    #1;
    // R1: quiet outputs during reset
    chk(!rv_l && !cv_l && !rv_b && !cv_b, "R1 reset outs",
        {28'd0, rv_b, cv_b, rv_l, cv_l}, 32'd0);
    rst_n = 1;
    // R1: pointer zero, data port closed
    acc(1'b0, 1'b0, 2'd0, 4, 0);
    acc(1'b1, 1'b0, 2'd0, 4, 0);
    acc(1'b1, 1'b1, 2'd0, 4, 32'h1234_5678);

    // R2: partial or misaligned pointer stores are discarded
    acc(1'b0, 1'b1, 2'd1, 4, 32'h8000_0001);
    acc(1'b0, 1'b1, 2'd0, 2, 32'h8000_0002);
    acc(1'b0, 1'b1, 2'd2, 1, 32'h8000_0003);
    acc(1'b0, 1'b1, 2'd3, 2, 32'h8000_0004);
    acc(1'b0, 1'b0, 2'd0, 4, 0);

    // R3: full pointer on any offset and length
    acc(1'b0, 1'b1, 2'd0, 4, 32'h80a5_3c10);
    for (int o = 0; o < 4; o++)
      for (int k = 0; k < 3; k++) acc(1'b0, 1'b0, 2'(o), lens[k], 0);

    // R4: enable clear
    acc(1'b0, 1'b1, 2'd0, 4, 32'h0011_2200);
    acc(1'b1, 1'b1, 2'd1, 2, 32'hdead_beef);
    acc(1'b1, 1'b0, 2'd2, 1, 0);

    // R7: absent device
    acc(1'b0, 1'b1, 2'd0, 4, 32'h80ee_0804);
    acc(1'b1, 1'b1, 2'd0, 4, 32'h0bad_f00d);
    acc(1'b1, 1'b0, 2'd0, 4, 0);

    // R5 R6 R8 R9: sweep every pointer offset with each window offset and length
    for (int r = 0; r < 256; r++) begin
      acc(1'b0, 1'b1, 2'd0, 4,
          {1'b1, 7'd0, 8'(r) ^ 8'h5a, 8'(r) + 8'd1, 8'(r)});
      for (int o = 0; o < 4; o++)
        for (int k = 0; k < 3; k++) begin
          acc(1'b1, 1'b0, 2'(o), lens[k], 0);
          if (r % 37 == 0 || r > 251)
            acc(1'b1, 1'b1, 2'(o), lens[k], 32'hc0de_0000 + 32'(r * 16 + o * 4 + k));
        end
    end

    summary();
    $finish;
  end
endmodule